// File: doc/BRIEF.md
# Window Alert Monitor with Hysteresis

This block watches the stream of results from a 12-bit converter. Each result comes with a one-cycle strobe that marks the end of a conversion. On every strobe the result is compared, as an unsigned number, against a programmable upper limit and a programmable lower limit. Each violated limit sets a sticky flag: over-range for the upper limit and under-range for the lower one. Software clears a flag by writing a one to it. When the hold bit is clear, a flag also clears by itself once a later result comes back inside its limit by more than the programmed hysteresis distance.

The alert is shown in three places, and two of them have their own enable bit. The status flags are always updated. The top bit of the stored result word can carry an alert marker. A dedicated alert output can be enabled, and its active level is programmable. A flat write/read port gives access to the limits, the configuration and the flags. Reads are combinational from the address.

Top module: `win_alert_top`

## Requirements
- R1: Flags and the stored result change only on a cycle with `conv_done` high, or on a status write. A change of `conv_data` without the strobe has no effect.
- R2: A result strictly greater than the upper limit (address 3) sets the over-range flag (status bit 1). A result strictly less than the lower limit (address 4) sets the under-range flag (status bit 0). Both flags can be set by one result.
- R3: Flags are set whatever the values of the enable bits in the configuration word (address 2).
- R4: Writing to the status word (address 1) clears each flag whose data bit is 1. A 0 bit leaves its flag unchanged.
- R5: With hold (config bit 0) at 0, the over-range flag clears when a result is below the upper limit minus the hysteresis (address 5), with the difference floored at 0. The under-range flag clears when a result is above the lower limit plus the hysteresis, with the sum capped at 4095.
- R6: With hold at 1, no result clears a flag. Only a status write clears it.
- R7: A set and a software clear of the same flag in the same cycle leave the flag set. A flag cleared while the input still violates its limit is set again by the next conversion.
- R8: Reading address 0 returns the last result in bits 11:0. Bit 15 is 1 exactly when flag-enable (config bit 1) is 1 and either flag is set. All other bits are 0.
- R9: With pin-enable (config bit 2) at 0, `alert_o` is inactive. Otherwise it is active while either flag is set. Polarity (config bit 3) at 0 means active low, and at 1 means active high.
- R10: After reset the upper limit reads 4095. The lower limit, hysteresis, configuration, flags and result all read 0, and `alert_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| conv_data | input | 12 | Conversion result, valid with the strobe |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| alert_o | output | 1 | Alert output, active level set by the polarity bit |

## Verification
The checker verifies on every cycle that the flags are unchanged when there is neither a strobe nor a status write. It also checks that a result beyond a limit always leaves the matching flag set on the next cycle, even when a clear is written in the same cycle. Further checks are that hold keeps a flag set until software clears it, and that a disabled pin sits at its inactive level. The hysteresis release points, the floor and cap on those thresholds, the result-word marker and the polarity of an enabled pin are shown only by the bench. The bench sweeps all sixteen configuration words across the input range against an arithmetic model, and adds targeted edge scenarios.

// File: rtl/win_alert_pkg.sv
package win_alert_pkg;

  typedef enum logic [2:0] {
    ADDR_RESULT = 3'd0,
    ADDR_STATUS = 3'd1,
    ADDR_CONFIG = 3'd2,
    ADDR_HIGH   = 3'd3,
    ADDR_LOW    = 3'd4,
    ADDR_HYST   = 3'd5
  } reg_addr_e;

  // packed from MSB: bit3 polarity, bit2 pin enable, bit1 flag enable, bit0 hold
  typedef struct packed {
    logic polarity;
    logic pin_en;
    logic flag_en;
    logic hold;
  } cfg_t;

  localparam int unsigned CFG_W     = 4;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned IDX_UNDER = 0;
  localparam int unsigned IDX_OVER  = 1;

endpackage

// File: rtl/win_alert_regs.sv
module win_alert_regs
  import win_alert_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output cfg_t             cfg_q,
  output logic [RES_W-1:0] high_q,
  output logic [RES_W-1:0] low_q,
  output logic [RES_W-1:0] hyst_q,
  output logic             status_wr,
  output logic [NUM_FLAGS-1:0] clr_mask
);

  logic unused_wbits;
  assign unused_wbits = ^wdata[BUS_W-1:RES_W];

  assign status_wr = wr_en && (addr == ADDR_STATUS);
  assign clr_mask  = status_wr ? wdata[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      high_q <= '1;
      low_q  <= '0;
      hyst_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_CONFIG: cfg_q  <= cfg_t'(wdata[CFG_W-1:0]);
        ADDR_HIGH:   high_q <= wdata[RES_W-1:0];
        ADDR_LOW:    low_q  <= wdata[RES_W-1:0];
        ADDR_HYST:   hyst_q <= wdata[RES_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/win_alert_cmp.sv
module win_alert_cmp #(
  parameter int unsigned RES_W = 12
) (
  input  logic [RES_W-1:0] sample,
  input  logic [RES_W-1:0] high_lim,
  input  logic [RES_W-1:0] low_lim,
  input  logic [RES_W-1:0] hyst,
  input  logic             hold,
  output logic             over_hit,
  output logic             under_hit,
  output logic             over_rel,
  output logic             under_rel
);

  // difference floored at zero
  function automatic logic [RES_W-1:0] floor_sub(input logic [RES_W-1:0] a,
                                                  input logic [RES_W-1:0] b);
    return (a >= b) ? (a - b) : '0;
  endfunction

  // sum capped at the largest code
  function automatic logic [RES_W-1:0] cap_add(input logic [RES_W-1:0] a,
                                                input logic [RES_W-1:0] b);
    logic [RES_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[RES_W] ? '1 : s[RES_W-1:0];
  endfunction

  logic [RES_W-1:0] over_release_lvl;
  logic [RES_W-1:0] under_release_lvl;

  assign over_release_lvl  = floor_sub(high_lim, hyst);
  assign under_release_lvl = cap_add(low_lim, hyst);

  assign over_hit  = sample > high_lim;
  assign under_hit = sample < low_lim;
  assign over_rel  = !hold && (sample < over_release_lvl);
  assign under_rel = !hold && (sample > under_release_lvl);

endmodule

// File: rtl/win_alert_flags.sv
module win_alert_flags
  import win_alert_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic [NUM_FLAGS-1:0] hit,
  input  logic [NUM_FLAGS-1:0] rel,
  input  logic [NUM_FLAGS-1:0] clr,
  output logic [NUM_FLAGS-1:0] flags_q
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic set_ev;
    logic drop_ev;
    assign set_ev  = conv_done && hit[i];
    assign drop_ev = clr[i] || (conv_done && rel[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_q[i] <= 1'b0;
      else if (set_ev)  flags_q[i] <= 1'b1;
      else if (drop_ev) flags_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/win_alert_view.sv
module win_alert_view
  import win_alert_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned BUS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  input  logic [2:0]           addr,
  input  cfg_t                 cfg_q,
  input  logic [RES_W-1:0]     high_q,
  input  logic [RES_W-1:0]     low_q,
  input  logic [RES_W-1:0]     hyst_q,
  input  logic [NUM_FLAGS-1:0] flags_q,
  output logic [BUS_W-1:0]     rdata,
  output logic                 alert_o
);

  localparam int unsigned PAD_W = BUS_W - RES_W - 1;

  logic [RES_W-1:0] result_q;
  logic             any_flag;
  logic             mark;
  logic             pin_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (conv_done) result_q <= conv_data;
  end

  assign any_flag   = |flags_q;
  assign mark       = cfg_q.flag_en && any_flag;
  assign pin_active = cfg_q.pin_en && any_flag;
  assign alert_o    = cfg_q.polarity ? pin_active : !pin_active;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_RESULT: rdata = {mark, {PAD_W{1'b0}}, result_q};
      ADDR_STATUS: rdata = {{(BUS_W-NUM_FLAGS){1'b0}}, flags_q};
      ADDR_CONFIG: rdata = {{(BUS_W-CFG_W){1'b0}}, cfg_q};
      ADDR_HIGH:   rdata = {{(BUS_W-RES_W){1'b0}}, high_q};
      ADDR_LOW:    rdata = {{(BUS_W-RES_W){1'b0}}, low_q};
      ADDR_HYST:   rdata = {{(BUS_W-RES_W){1'b0}}, hyst_q};
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/win_alert_top.sv
module win_alert_top
  import win_alert_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             alert_o
);

  cfg_t                 cfg_q;
  logic [RES_W-1:0]     high_q;
  logic [RES_W-1:0]     low_q;
  logic [RES_W-1:0]     hyst_q;
  logic                 status_wr;
  logic [NUM_FLAGS-1:0] clr_mask;
  logic                 over_hit;
  logic                 under_hit;
  logic                 over_rel;
  logic                 under_rel;
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 over_q;
  logic                 under_q;

  win_alert_regs #(.RES_W(RES_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .cfg_q(cfg_q), .high_q(high_q), .low_q(low_q),
    .hyst_q(hyst_q), .status_wr(status_wr), .clr_mask(clr_mask)
  );

  win_alert_cmp #(.RES_W(RES_W)) cmp_i (
    .sample(conv_data), .high_lim(high_q), .low_lim(low_q), .hyst(hyst_q),
    .hold(cfg_q.hold), .over_hit(over_hit), .under_hit(under_hit),
    .over_rel(over_rel), .under_rel(under_rel)
  );

  win_alert_flags flags_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
    .hit({over_hit, under_hit}), .rel({over_rel, under_rel}),
    .clr(clr_mask), .flags_q(flags_q)
  );

  assign over_q  = flags_q[IDX_OVER];
  assign under_q = flags_q[IDX_UNDER];

  win_alert_view #(.RES_W(RES_W), .BUS_W(BUS_W)) view_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .addr(reg_addr), .cfg_q(cfg_q), .high_q(high_q), .low_q(low_q),
    .hyst_q(hyst_q), .flags_q(flags_q), .rdata(reg_rdata), .alert_o(alert_o)
  );

endmodule

// File: rtl/win_alert_chk.sv
module win_alert_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_data,
  input logic [RES_W-1:0] high_q,
  input logic [RES_W-1:0] low_q,
  input logic             status_wr,
  input logic [1:0]       clr_bits,
  input logic             hold,
  input logic             pin_en,
  input logic             polarity,
  input logic             over_q,
  input logic             under_q,
  input logic             alert_o
);

  // R1: no strobe and no status write keeps both flags
  a_r1_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !status_wr) |=> ($stable(over_q) && $stable(under_q)));

  // R2 / R7: a violation always leaves the flag set, even against a clear
  a_r2_over_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (conv_data > high_q)) |=> over_q);

  a_r2_under_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (conv_data < low_q)) |=> under_q);

  // R6: with hold, only a software clear drops a flag
  a_r6_hold_over: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && over_q && !(status_wr && clr_bits[1])) |=> over_q);

  a_r6_hold_under: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && under_q && !(status_wr && clr_bits[0])) |=> under_q);

  // R9: a disabled pin sits at its inactive level
  a_r9_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> (alert_o == !polarity));

endmodule

bind win_alert_top win_alert_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .high_q(high_q), .low_q(low_q), .status_wr(status_wr),
  .clr_bits(reg_wdata[1:0]), .hold(cfg_q.hold), .pin_en(cfg_q.pin_en),
  .polarity(cfg_q.polarity), .over_q(over_q), .under_q(under_q),
  .alert_o(alert_o)
);

// File: tb/win_alert_top_tb_top.sv
`timescale 1ns/1ps
module win_alert_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        alert_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int  m_hi = 4095, m_lo = 0, m_hy = 0, m_res = 0;
  bit  m_over = 0, m_under = 0;
  bit [3:0] m_cfg = 0;

  always #5 clk = ~clk;

  win_alert_top dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alert_o(alert_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (a)
      3'd1: begin if (d & 2) m_over = 0; if (d & 1) m_under = 0; end
      3'd2: m_cfg = 4'(d);
      3'd3: m_hi = d & 12'hfff;
      3'd4: m_lo = d & 12'hfff;
      3'd5: m_hy = d & 12'hfff;
      default: ;
    endcase
  endtask

  function automatic void model_conv(input int v);
    int rel_hi, rel_lo;
    rel_hi = m_hi - m_hy; if (rel_hi < 0) rel_hi = 0;
    rel_lo = m_lo + m_hy; if (rel_lo > 4095) rel_lo = 4095;
    m_res = v;
    if (v > m_hi) m_over = 1;
    else if (!m_cfg[0] && v < rel_hi) m_over = 0;
    if (v < m_lo) m_under = 1;
    else if (!m_cfg[0] && v > rel_lo) m_under = 0;
  endfunction

  task automatic conv(input int v);
    @(negedge clk);
    conv_done = 1'b1; conv_data = 12'(v);
    @(negedge clk);
    conv_done = 1'b0;
    model_conv(v);
  endtask

  // same-cycle conversion and status clear
  task automatic conv_and_clear(input int v, input int bits);
    @(negedge clk);
    conv_done = 1'b1; conv_data = 12'(v);
    reg_wr_en = 1'b1; reg_addr = 3'd1; reg_wdata = 16'(bits);
    @(negedge clk);
    conv_done = 1'b0; reg_wr_en = 1'b0;
    if (bits & 2) m_over = 0;
    if (bits & 1) m_under = 0;
    model_conv(v);
  endtask

  function automatic int exp_alert();
    bit act;
    act = m_cfg[2] && (m_over || m_under);
    return m_cfg[3] ? int'(act) : int'(!act);
  endfunction

  task automatic check_all(input string req);
    int v;
    rd(3'd1, v); check(req, v, (int'(m_over) << 1) | int'(m_under));
    rd(3'd0, v); check({req, "/R8"}, v,
                       ((m_cfg[1] && (m_over || m_under)) ? 32'h8000 : 0) | m_res);
    check({req, "/R9"}, int'(alert_o), exp_alert());
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    rd(3'd0, v); check("R10 result", v, 0);
    rd(3'd1, v); check("R10 status", v, 0);
    rd(3'd2, v); check("R10 config", v, 0);
    rd(3'd3, v); check("R10 high", v, 4095);
    rd(3'd4, v); check("R10 low", v, 0);
    rd(3'd5, v); check("R10 hyst", v, 0);
    check("R10 alert", int'(alert_o), 1);

    // R2/R3/R5/R6/R8/R9: all configurations swept over the input range
    wr(3'd3, 3000); wr(3'd4, 1000); wr(3'd5, 200);
    for (int c = 0; c < 16; c++) begin
      wr(3'd2, c);
      wr(3'd1, 3);
      for (int x = 0; x < 4096; x += 97) begin conv(x); check_all("R2 up"); end
      for (int x = 4095; x >= 0; x -= 89) begin conv(x); check_all("R5 down"); end
      conv(2000); check_all("R6 mid");
    end

    // R2: both flags from one result with crossed limits
    wr(3'd2, 4'b0110); wr(3'd1, 3);
    wr(3'd3, 500); wr(3'd4, 3500); wr(3'd5, 0);
    conv(2000); check_all("R2 both");
    check("R2 both bits", int'(m_over && m_under), 1);

    // R1: data moves without the strobe
    wr(3'd3, 3000); wr(3'd4, 1000); wr(3'd5, 0); wr(3'd1, 3);
    conv(2000); check_all("R1 base");
    @(negedge clk); conv_data = 12'd4000;
    @(negedge clk); conv_data = 12'd10;
    @(negedge clk); conv_data = 12'd2000;
    check_all("R1 nostrobe");

    // R4: zero bits leave flags; a one clears only its own flag
    wr(3'd2, 4'b0001);
    conv(4000); conv(10);
    check_all("R4 setboth");
    wr(3'd1, 0); check_all("R4 zero");
    wr(3'd1, 2); check_all("R4 over");
    wr(3'd1, 1); check_all("R4 under");

    // R7: set wins over same-cycle clear; re-arm after clear
    conv_and_clear(4000, 3); check_all("R7 setwins");
    rd(3'd1, v); check("R7 over kept", v, 2);
    wr(3'd1, 2); rd(3'd1, v); check("R7 cleared", v, 0);
    conv(3500); rd(3'd1, v); check("R7 rearm", v, 2);

    // R5: saturation of release levels
    wr(3'd2, 0); wr(3'd1, 3);
    wr(3'd3, 10); wr(3'd5, 50); wr(3'd4, 4090);
    conv(20); conv(0); check_all("R5 floor");
    rd(3'd1, v); check("R5 floor over kept", v & 2, 2);
    conv(4095); check_all("R5 cap");
    rd(3'd1, v); check("R5 cap under kept", v & 1, 1);
    wr(3'd5, 0); conv(4095); check_all("R5 release");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule